// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the software-facing control register file for one channel of a bus-master disk DMA controller. It holds a command byte (start and direction), a status byte (active, error and interrupt flags) and a 32-bit descriptor table base pointer. A simple strobe-based access port, with a register select, a byte offset and an access size, reaches these registers. Reads return data one cycle after the read strobe.

The block does not walk descriptors or move data. It sends one-cycle start and cancel strobes, the transfer direction and a current descriptor pointer to the descriptor engine. It takes back end-of-transfer, "more work" and error indications. The drive interrupt line passes straight through to the host. A rising edge on it latches the interrupt flag in status. A synchronous active-high reset returns every register to zero.

Top module: `bm_chan_regs`

## Requirements
- R1: A write to the command register (select 0) stores only bits 0 (start) and 3 (direction) of the written byte. A command read returns the stored byte with all other bits zero, and `xfer_dir` follows bit 3.
- R2: A command write that changes start from 0 to 1 loads `cur_ptr` with the table base. If status bit 0 (active) was clear, it also sets active and pulses `eng_start` high for exactly one cycle, in the cycle after the write.
- R3: A command write that leaves the start bit unchanged causes no `eng_start` or `eng_cancel` pulse. It does not reload `cur_ptr` and does not change active.
- R4: A command write that changes start from 1 to 0 pulses `eng_cancel` for one cycle and clears active in the same cycle.
- R5: Setting start while active is already set reloads `cur_ptr` but produces no `eng_start` pulse.
- R6: When `eng_done` is high, active takes the value of `eng_more`.
- R7: `host_irq` equals `drv_irq` in every cycle. A rising edge of `drv_irq` sets status bit 2 (interrupt). A level held high does not set the bit again once software has cleared it.
- R8: Status bits 1 (error) and 2 (interrupt) are cleared by writing 1 to them through a status write (select 1), and are unchanged by writing 0. Bit 0 cannot be written. `eng_err` sets bit 1.
- R9: A table base write (select 2) replaces only the bytes selected by the offset and the size (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). Write data is right-aligned, and bits 1:0 of the base are always zero.
- R10: A table base read returns the base shifted right by 8 × offset and masked to the access size.
- R11: Reset clears command, status, table base, `cur_ptr` and the read data, and no strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 command, 1 status, 2 table base |
| reg_off | input | 2 | Byte offset within the table base |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| reg_wdata | input | 32 | Right-aligned write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| eng_start | output | 1 | One-cycle start strobe to the engine |
| eng_cancel | output | 1 | One-cycle cancel strobe to the engine |
| xfer_dir | output | 1 | Transfer direction from command bit 3 |
| cur_ptr | output | 32 | Current descriptor pointer |
| eng_done | input | 1 | Engine end-of-transfer indication |
| eng_more | input | 1 | With eng_done: more work remains |
| eng_err | input | 1 | Engine error indication |
| drv_irq | input | 1 | Drive interrupt request |
| host_irq | output | 1 | Interrupt forwarded upstream |

## Verification
A wrong start-edge decision shows within one cycle of the command write: the engine sees an extra or missing `eng_start` or `eng_cancel` pulse, or `cur_ptr` moves when it should stay. A corrupted active, error or interrupt flag stays hidden until the next status read, which shows it one cycle after the read strobe. A table base merged into the wrong byte lanes shows the cycle after the next start, as a wrong `cur_ptr`, or on a read back at any offset.

// File: rtl/bm_regs_pkg.sv
package bm_regs_pkg;
    localparam int unsigned PTR_W  = 32;
    localparam int unsigned BYTE_W = 8;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_BASE = 2'd2;

    localparam int unsigned CMD_GO  = 0;
    localparam int unsigned CMD_DIR = 3;
    localparam logic [BYTE_W-1:0] CMD_KEEP = 8'h09;

    localparam int unsigned ST_ACT = 0;
    localparam int unsigned ST_ERR = 1;
    localparam int unsigned ST_INT = 2;

    typedef struct packed {
        logic act;
        logic err;
        logic intr;
        logic irq_prev;
    } stat_t;
endpackage

// File: rtl/bm_cmd_ctrl.sv
module bm_cmd_ctrl
    import bm_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              act_q,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              go_set,
    output logic              go_clr,
    output logic              eng_start,
    output logic              eng_cancel
);
    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic              start_p;
        logic              cancel_p;
    } cmd_state_t;

    cmd_state_t st_d, st_q;

    assign go_set = wr_cmd &&  wbyte[CMD_GO] && !st_q.cmd[CMD_GO];
    assign go_clr = wr_cmd && !wbyte[CMD_GO] &&  st_q.cmd[CMD_GO];

    always_comb begin
        st_d          = st_q;
        st_d.start_p  = go_set && !act_q;
        st_d.cancel_p = go_clr;
        if (wr_cmd) begin
            st_d.cmd = wbyte & CMD_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cmd_q      = st_q.cmd;
    assign eng_start  = st_q.start_p;
    assign eng_cancel = st_q.cancel_p;

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(eng_start && eng_cancel));

    // R3
    start_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> cmd_q[CMD_GO]);
endmodule

// File: rtl/bm_status.sv
module bm_status
    import bm_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_set,
    input  logic              go_clr,
    input  logic              wr_stat,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              eng_done,
    input  logic              eng_more,
    input  logic              eng_err,
    input  logic              drv_irq,
    output logic [BYTE_W-1:0] stat_q
);
    stat_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.irq_prev = drv_irq;
        if (eng_done) s_d.act = eng_more;
        if (go_set)   s_d.act = 1'b1;
        if (go_clr)   s_d.act = 1'b0;
        if (wr_stat && wbyte[ST_ERR]) s_d.err  = 1'b0;
        if (wr_stat && wbyte[ST_INT]) s_d.intr = 1'b0;
        if (eng_err)                  s_d.err  = 1'b1;
        if (drv_irq && !s_q.irq_prev) s_d.intr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        stat_q         = '0;
        stat_q[ST_ACT] = s_q.act;
        stat_q[ST_ERR] = s_q.err;
        stat_q[ST_INT] = s_q.intr;
    end

    // R7
    int_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[ST_INT]) |-> $past(drv_irq));

    // R8
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[ST_ERR]) |-> $past(eng_err));
endmodule

// File: rtl/bm_base_ptr.sv
module bm_base_ptr
    import bm_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_base,
    input  logic [PTR_W-1:0] wdata,
    input  logic [1:0]       off,
    input  logic [1:0]       size,
    input  logic             go_set,
    output logic [PTR_W-1:0] base_q,
    output logic [PTR_W-1:0] ptr_q
);
    localparam int unsigned SH_W = $clog2(PTR_W);

    typedef struct packed {
        logic [PTR_W-1:0] base;
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t p_d, p_q;
    logic [PTR_W-1:0] lane_mask;
    logic [SH_W-1:0]  sh;

    always_comb begin
        case (size)
            2'd0:    lane_mask = PTR_W'(32'h0000_00FF);
            2'd1:    lane_mask = PTR_W'(32'h0000_FFFF);
            default: lane_mask = '1;
        endcase
        sh = SH_W'({off, 3'b000});
    end

    always_comb begin
        p_d = p_q;
        if (wr_base) begin
            p_d.base = (p_q.base & ~(lane_mask << sh))
                     | ((wdata & lane_mask) << sh);
            p_d.base[1:0] = 2'b00;
        end
        if (go_set) p_d.ptr = p_q.base;
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign base_q = p_q.base;
    assign ptr_q  = p_q.ptr;

    // R9
    ptr_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr_q) |-> (ptr_q[1:0] == 2'b00));
endmodule

// File: rtl/bm_chan_regs.sv
module bm_chan_regs
    import bm_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_sel,
    input  logic [1:0]       reg_off,
    input  logic [1:0]       reg_size,
    input  logic [PTR_W-1:0] reg_wdata,
    output logic [PTR_W-1:0] reg_rdata,
    output logic             eng_start,
    output logic             eng_cancel,
    output logic             xfer_dir,
    output logic [PTR_W-1:0] cur_ptr,
    input  logic             eng_done,
    input  logic             eng_more,
    input  logic             eng_err,
    input  logic             drv_irq,
    output logic             host_irq
);
    typedef struct packed {
        logic [PTR_W-1:0] rdata;
    } rd_state_t;

    rd_state_t r_d, r_q;

    logic [BYTE_W-1:0] cmd_q, stat_q;
    logic [PTR_W-1:0]  base_q;
    logic              go_set, go_clr;
    logic              wr_cmd, wr_stat, wr_base;
    logic [PTR_W-1:0]  rd_mask;

    assign wr_cmd  = reg_wr && (reg_sel == SEL_CMD);
    assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
    assign wr_base = reg_wr && (reg_sel == SEL_BASE);

    bm_cmd_ctrl u_cmd (
        .clk        (clk),
        .rst        (rst),
        .wr_cmd     (wr_cmd),
        .wbyte      (reg_wdata[BYTE_W-1:0]),
        .act_q      (stat_q[ST_ACT]),
        .cmd_q      (cmd_q),
        .go_set     (go_set),
        .go_clr     (go_clr),
        .eng_start  (eng_start),
        .eng_cancel (eng_cancel)
    );

    bm_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .go_set   (go_set),
        .go_clr   (go_clr),
        .wr_stat  (wr_stat),
        .wbyte    (reg_wdata[BYTE_W-1:0]),
        .eng_done (eng_done),
        .eng_more (eng_more),
        .eng_err  (eng_err),
        .drv_irq  (drv_irq),
        .stat_q   (stat_q)
    );

    bm_base_ptr u_base (
        .clk     (clk),
        .rst     (rst),
        .wr_base (wr_base),
        .wdata   (reg_wdata),
        .off     (reg_off),
        .size    (reg_size),
        .go_set  (go_set),
        .base_q  (base_q),
        .ptr_q   (cur_ptr)
    );

    always_comb begin
        case (reg_size)
            2'd0:    rd_mask = PTR_W'(32'h0000_00FF);
            2'd1:    rd_mask = PTR_W'(32'h0000_FFFF);
            default: rd_mask = '1;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (reg_rd) begin
            case (reg_sel)
                SEL_CMD:  r_d.rdata = PTR_W'(cmd_q);
                SEL_STAT: r_d.rdata = PTR_W'(stat_q);
                SEL_BASE: r_d.rdata = (base_q >> {reg_off, 3'b000}) & rd_mask;
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign reg_rdata = r_q.rdata;
    assign xfer_dir  = cmd_q[CMD_DIR];
    assign host_irq  = drv_irq;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (stat_q[ST_ACT] && cur_ptr == $past(base_q)));

    // R4
    cancel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        eng_cancel |-> !stat_q[ST_ACT]);
endmodule

// File: tb/bm_chan_regs_test.sv
module bm_chan_regs_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [1:0]  reg_sel, reg_off, reg_size;
    logic [31:0] reg_wdata, reg_rdata, cur_ptr;
    logic        eng_start, eng_cancel, xfer_dir;
    logic        eng_done, eng_more, eng_err, drv_irq, host_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bm_chan_regs uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_off(reg_off), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_start(eng_start), .eng_cancel(eng_cancel), .xfer_dir(xfer_dir),
        .cur_ptr(cur_ptr), .eng_done(eng_done), .eng_more(eng_more),
        .eng_err(eng_err), .drv_irq(drv_irq), .host_irq(host_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d, logic [1:0] off = 0, logic [1:0] sz = 2);
        reg_wr = 1; reg_sel = sel; reg_wdata = d; reg_off = off; reg_size = sz;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [31:0] d, input logic [1:0] off = 0, input logic [1:0] sz = 2);
        reg_rd = 1; reg_sel = sel; reg_off = off; reg_size = sz;
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R11 start", {31'b0, eng_start}, 0);
        check("R11 cancel", {31'b0, eng_cancel}, 0);
        check("R11 ptr", cur_ptr, 0);
        check("R11 rdata", reg_rdata, 0);
        rd(0, v); check("R11 cmd", v, 0);
        rd(1, v); check("R11 stat", v, 0);
        rd(2, v); check("R11 base", v, 0);
    endtask

    task automatic t_base();
        logic [31:0] v;
        wr(2, 32'h1234_5677);
        rd(2, v); check("R9 word write low bits", v, 32'h1234_5674);
        wr(2, 32'h0000_00AB, 2, 0);
        rd(2, v); check("R9 byte lane 2", v, 32'h12AB_5674);
        wr(2, 32'h0000_FFFF, 0, 1);
        rd(2, v); check("R9 half lane 0", v, 32'h12AB_FFFC);
        rd(2, v, 1, 0); check("R10 byte off1", v, 32'h0000_00FF);
        rd(2, v, 2, 1); check("R10 half off2", v, 32'h0000_12AB);
        rd(2, v, 3, 0); check("R10 byte off3", v, 32'h0000_0012);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        logic [31:0] p0;
        wr(0, 32'hFF);
        check("R2 start pulse", {31'b0, eng_start}, 1);
        check("R2 ptr load", cur_ptr, 32'h12AB_FFFC);
        check("R1 dir", {31'b0, xfer_dir}, 1);
        @(negedge clk);
        check("R2 pulse one cycle", {31'b0, eng_start}, 0);
        rd(0, v); check("R1 cmd mask", v, 32'h09);
        rd(1, v); check("R2 active set", v, 32'h01);
        wr(2, 32'h0000_4000);
        p0 = cur_ptr;
        wr(0, 32'h01);
        check("R3 no start", {31'b0, eng_start}, 0);
        check("R3 no cancel", {31'b0, eng_cancel}, 0);
        check("R3 ptr kept", cur_ptr, p0);
        check("R1 dir cleared", {31'b0, xfer_dir}, 0);
        rd(1, v); check("R3 active kept", v, 32'h01);
        wr(0, 32'h00);
        check("R4 cancel", {31'b0, eng_cancel}, 1);
        rd(1, v); check("R4 active clr", v, 32'h00);
        check("R4 cancel one cycle", {31'b0, eng_cancel}, 0);
        wr(0, 32'h00);
        check("R3 no cancel when idle", {31'b0, eng_cancel}, 0);
    endtask

    task automatic t_done();
        logic [31:0] v;
        eng_done = 1; eng_more = 1;
        @(negedge clk);
        eng_done = 0; eng_more = 0;
        rd(1, v); check("R6 more keeps active", v, 32'h01);
        wr(0, 32'h01);
        check("R5 no start when active", {31'b0, eng_start}, 0);
        check("R5 ptr reload", cur_ptr, 32'h0000_4000);
        eng_done = 1;
        @(negedge clk);
        eng_done = 0;
        rd(1, v); check("R6 done clears active", v, 32'h00);
        wr(0, 32'h00);
    endtask

    task automatic t_irq_err();
        logic [31:0] v;
        drv_irq = 1;
        #1 check("R7 passthrough high", {31'b0, host_irq}, 1);
        @(negedge clk);
        rd(1, v); check("R7 int set", v, 32'h04);
        wr(1, 32'h04);
        rd(1, v); check("R7 level no reset", v, 32'h00);
        drv_irq = 0;
        #1 check("R7 passthrough low", {31'b0, host_irq}, 0);
        @(negedge clk);
        rd(1, v); check("R7 low no change", v, 32'h00);
        eng_err = 1; drv_irq = 1;
        @(negedge clk);
        eng_err = 0;
        rd(1, v); check("R8 err and int", v, 32'h06);
        wr(1, 32'h01);
        rd(1, v); check("R8 write 0 keeps, bit0 ro", v, 32'h06);
        wr(1, 32'h02);
        rd(1, v); check("R8 w1c err", v, 32'h04);
        wr(1, 32'h04);
        rd(1, v); check("R8 w1c int", v, 32'h00);
        drv_irq = 0;
    endtask

    task automatic t_reset_busy();
        logic [31:0] v;
        wr(2, 32'h8000_0010);
        wr(0, 32'h09);
        do_reset();
        check("R11 ptr after busy", cur_ptr, 0);
        check("R11 dir", {31'b0, xfer_dir}, 0);
        rd(1, v); check("R11 stat after busy", v, 0);
        rd(2, v); check("R11 base after busy", v, 0);
    endtask

    initial begin
        reg_wr = 0; reg_rd = 0; reg_sel = 0; reg_off = 0; reg_size = 2;
        reg_wdata = 0; eng_done = 0; eng_more = 0; eng_err = 0; drv_irq = 0;
        rst = 1;
        @(negedge clk);
        t_reset();
        t_base();
        t_cmd();
        t_done();
        t_irq_err();
        t_reset_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule